// File: doc/BRIEF.md
# Strobe-Only External FIFO Bridge

This block moves single bytes between an internal request port and an external 8-bit FIFO chip. The chip sees only three things: an 8-bit data bus, an active-low read strobe and an active-low write strobe. There are no address lines and no latch strobe. A request is accepted when the bridge is idle. It then waits in a hold-off phase until the external flags allow the transfer. After that it drives the matching strobe for a fixed two clocks and reports completion with a one-cycle done pulse.

The external full flag can hold off writes and the external empty flag can hold off reads, and each of the two has its own enable. A hold-off timer counts the clocks a transaction spends stalled. When the count reaches a programmable 8-bit limit, the transaction is dropped without any strobe, done is reported together with an error indication, and a sticky error flag is set. A limit of zero turns the timer off. The flags are assumed to be synchronous to the bridge clock already.

Top module: `extfifo_bridge`

## Requirements
- R1: After reset both strobes are high (inactive), done and the error flag are low, the request port is ready, and the hold-off limit is 0xFF.
- R2: A write that is not stalled drives the write strobe low for exactly 2 clocks, starting in the second clock after the accepting edge. During the strobe the bridge drives the request byte on ext_dout with ext_doe high. done is high for one clock, in the clock right after the strobe ends.
- R3: A read that is not stalled drives the read strobe low for exactly 2 clocks. rdata takes the value ext_din has at the end of the second strobe clock, and done follows in the same way as for a write.
- R4: While full_gate_en is 1 and ext_full is 1, a pending write asserts no strobe. The strobe starts in the clock after the first hold-off clock in which the flag is seen low.
- R5: While empty_gate_en is 1 and ext_empty is 1, a pending read asserts no strobe. The strobe starts in the clock after the first hold-off clock in which the flag is seen low.
- R6: A flag whose enable is 0 has no effect. The full flag never stalls a read, and the empty flag never stalls a write.
- R7: With a nonzero limit L, a transaction stalled for L hold-off clocks is aborted without any strobe. done and done_err are then high together for one clock, in the clock after the L-th stalled clock, and err_flag sets at the same edge.
- R8: With a limit of 0, a stalled transaction waits without limit and never raises done_err.
- R9: The limit is loaded from cfg_limit_val on a clock where cfg_limit_we is 1, and it holds its value otherwise.
- R10: err_flag stays set until err_clr is 1 on a clock edge. A new abort at the same edge takes priority over the clear.
- R11: Once a strobe has started, changes on the flags do not shorten it or extend it.
- R12: req_ready is low from the accepting edge until done rises, and no request is accepted while a strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Byte to write |
| req_ready | output | 1 | Bridge idle and able to accept a request |
| full_gate_en | input | 1 | Allow the full flag to stall writes |
| empty_gate_en | input | 1 | Allow the empty flag to stall reads |
| cfg_limit_we | input | 1 | Load the hold-off limit |
| cfg_limit_val | input | 8 | New hold-off limit, 0 = no limit |
| err_clr | input | 1 | Clear the sticky error flag |
| ext_full | input | 1 | External FIFO full flag |
| ext_empty | input | 1 | External FIFO empty flag |
| ext_din | input | 8 | Data from the external FIFO |
| ext_dout | output | 8 | Data to the external FIFO |
| ext_doe | output | 1 | Output enable for ext_dout |
| ext_rd_n | output | 1 | Read strobe, active low |
| ext_wr_n | output | 1 | Write strobe, active low |
| done | output | 1 | One-clock completion pulse |
| done_err | output | 1 | Marks a done that was caused by a hold-off abort |
| rdata | output | 8 | Last byte read |
| err_flag | output | 1 | Sticky hold-off error |

## Verification
The bound checker watches, on every clock, the properties that hold at all times. The two strobes are never low together. Each strobe lasts exactly two clocks and never starts in a clock after one where its enabled flag was high. Write data is driven while the write strobe is low. done is a single pulse, an abort always shows on err_flag, the error stays set until it is cleared, and no request is ready while a strobe is active. What the timing looks like from the outside needs the bench's scenarios. That covers the exact clock in which the strobe starts after a stall of a given length, the abort clock for each swept limit, which edge captures the read data, endless waiting with a limit of zero, and the reset value 0xFF, checked through a 255-clock abort.

// File: rtl/efb_pkg.sv
package efb_pkg;
  localparam int unsigned DATA_W_DEF = 8;
  localparam int unsigned CNT_W_DEF  = 8;
  localparam int unsigned STROBE_DEF = 2;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_HOLD   = 2'd1,
    ST_STROBE = 2'd2
  } xfer_state_e;
endpackage

// File: rtl/efb_rst_sync.sv
module efb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] chain_q;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n_in) begin
          if (!rst_n_in) chain_q[gi] <= 1'b0;
          else           chain_q[gi] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n_in) begin
          if (!rst_n_in) chain_q[gi] <= 1'b0;
          else           chain_q[gi] <= chain_q[gi-1];
        end
      end
    end
  endgenerate

  assign rst_n_out = chain_q[STAGES-1];
endmodule

// File: rtl/efb_stall_gate.sv
module efb_stall_gate (
  input  logic is_write,
  input  logic full_en,
  input  logic empty_en,
  input  logic ext_full,
  input  logic ext_empty,
  output logic stall
);
  logic wr_block;
  logic rd_block;

  always_comb begin
    wr_block = full_en  & ext_full;
    rd_block = empty_en & ext_empty;
    stall    = is_write ? wr_block : rd_block;
  end
endmodule

// File: rtl/efb_holdoff_timer.sv
module efb_holdoff_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             limit_on;

  always_comb begin
    limit_on = (limit != '0);
    expire   = tick && limit_on && (cnt_q == limit - CNT_W'(1));
    cnt_en   = restart | tick;
    cnt_d    = restart ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/efb_limit_reg.sv
module efb_limit_reg #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] value,
  output logic [CNT_W-1:0] limit
);
  logic [CNT_W-1:0] limit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    limit_q <= '1;
    else if (load) limit_q <= value;
  end

  assign limit = limit_q;
endmodule

// File: rtl/efb_strobe_seq.sv
module efb_strobe_seq
  import efb_pkg::*;
#(
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned STROBE_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              stall,
  input  logic              expire,
  input  logic [DATA_W-1:0] ext_din,
  output logic              accept,
  output logic              in_hold,
  output logic              cur_write,
  output logic              req_ready,
  output logic              rd_n,
  output logic              wr_n,
  output logic [DATA_W-1:0] dout,
  output logic              doe,
  output logic              done,
  output logic              done_err,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned PH_W = (STROBE_CYCLES > 1) ? $clog2(STROBE_CYCLES) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(STROBE_CYCLES - 1);

  xfer_state_e       state_q, state_d;
  logic [PH_W-1:0]   phase_q, phase_d;
  logic              write_q, write_d;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              done_q, done_d;
  logic              derr_q, derr_d;
  logic              wdata_en;
  logic              rdata_en;

  always_comb begin
    state_d  = state_q;
    phase_d  = phase_q;
    write_d  = write_q;
    done_d   = 1'b0;
    derr_d   = 1'b0;
    wdata_en = 1'b0;
    rdata_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          state_d  = ST_HOLD;
          write_d  = req_write;
          wdata_en = req_write;
        end
      end
      ST_HOLD: begin
        if (!stall) begin
          state_d = ST_STROBE;
          phase_d = '0;
        end else if (expire) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          derr_d  = 1'b1;
        end
      end
      ST_STROBE: begin
        if (phase_q == PH_LAST) begin
          state_d  = ST_IDLE;
          done_d   = 1'b1;
          rdata_en = ~write_q;
        end else begin
          phase_d = phase_q + PH_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= '0;
      write_q <= 1'b0;
      done_q  <= 1'b0;
      derr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      write_q <= write_d;
      done_q  <= done_d;
      derr_q  <= derr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wdata_q <= '0;
    else if (wdata_en) wdata_q <= req_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_q <= '0;
    else if (rdata_en) rdata_q <= ext_din;
  end

  always_comb begin
    accept    = (state_q == ST_IDLE) && req_valid;
    in_hold   = (state_q == ST_HOLD);
    cur_write = write_q;
    req_ready = (state_q == ST_IDLE);
    wr_n      = !((state_q == ST_STROBE) && write_q);
    rd_n      = !((state_q == ST_STROBE) && !write_q);
    doe       = write_q && (state_q != ST_IDLE);
    dout      = wdata_q;
    done      = done_q;
    done_err  = derr_q;
    rdata     = rdata_q;
  end
endmodule

// File: rtl/extfifo_bridge.sv
module extfifo_bridge
  import efb_pkg::*;
#(
  parameter int unsigned DATA_W        = DATA_W_DEF,
  parameter int unsigned CNT_W         = CNT_W_DEF,
  parameter int unsigned STROBE_CYCLES = STROBE_DEF,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  input  logic              full_gate_en,
  input  logic              empty_gate_en,
  input  logic              cfg_limit_we,
  input  logic [CNT_W-1:0]  cfg_limit_val,
  input  logic              err_clr,
  input  logic              ext_full,
  input  logic              ext_empty,
  input  logic [DATA_W-1:0] ext_din,
  output logic [DATA_W-1:0] ext_dout,
  output logic              ext_doe,
  output logic              ext_rd_n,
  output logic              ext_wr_n,
  output logic              done,
  output logic              done_err,
  output logic [DATA_W-1:0] rdata,
  output logic              err_flag
);
  logic             srst_n;
  logic             accept;
  logic             in_hold;
  logic             cur_write;
  logic             stall;
  logic             expire;
  logic [CNT_W-1:0] limit;
  logic             err_q, err_d, err_en;

  efb_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (srst_n)
  );

  efb_limit_reg #(.CNT_W(CNT_W)) u_limit (
    .clk   (clk),
    .rst_n (srst_n),
    .load  (cfg_limit_we),
    .value (cfg_limit_val),
    .limit (limit)
  );

  efb_stall_gate u_gate (
    .is_write  (cur_write),
    .full_en   (full_gate_en),
    .empty_en  (empty_gate_en),
    .ext_full  (ext_full),
    .ext_empty (ext_empty),
    .stall     (stall)
  );

  efb_holdoff_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (srst_n),
    .restart (accept),
    .tick    (in_hold & stall),
    .limit   (limit),
    .expire  (expire)
  );

  efb_strobe_seq #(
    .DATA_W        (DATA_W),
    .STROBE_CYCLES (STROBE_CYCLES)
  ) u_seq (
    .clk       (clk),
    .rst_n     (srst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_wdata (req_wdata),
    .stall     (stall),
    .expire    (expire),
    .ext_din   (ext_din),
    .accept    (accept),
    .in_hold   (in_hold),
    .cur_write (cur_write),
    .req_ready (req_ready),
    .rd_n      (ext_rd_n),
    .wr_n      (ext_wr_n),
    .dout      (ext_dout),
    .doe       (ext_doe),
    .done      (done),
    .done_err  (done_err),
    .rdata     (rdata)
  );

  // Sticky error: an abort at the same edge wins over a clear.
  always_comb begin
    err_en = (in_hold & expire) | err_clr;
    err_d  = in_hold & expire;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     err_q <= 1'b0;
    else if (err_en) err_q <= err_d;
  end

  assign err_flag = err_q;
endmodule

// File: rtl/efb_checker.sv
module efb_checker (
  input logic clk,
  input logic srst_n,
  input logic req_ready,
  input logic full_gate_en,
  input logic empty_gate_en,
  input logic ext_full,
  input logic ext_empty,
  input logic ext_doe,
  input logic ext_rd_n,
  input logic ext_wr_n,
  input logic done,
  input logic done_err,
  input logic err_clr,
  input logic err_flag
);
  assert_strobe_exclusive_R2: assert property (@(posedge clk) disable iff (!srst_n)
    !(!ext_rd_n && !ext_wr_n));

  assert_wr_second_cycle_R2: assert property (@(posedge clk) disable iff (!srst_n)
    $fell(ext_wr_n) |=> !ext_wr_n);

  assert_wr_ends_R2: assert property (@(posedge clk) disable iff (!srst_n)
    (!ext_wr_n && $past(!ext_wr_n)) |=> ext_wr_n);

  assert_rd_second_cycle_R3: assert property (@(posedge clk) disable iff (!srst_n)
    $fell(ext_rd_n) |=> !ext_rd_n);

  assert_rd_ends_R3: assert property (@(posedge clk) disable iff (!srst_n)
    (!ext_rd_n && $past(!ext_rd_n)) |=> ext_rd_n);

  assert_wdata_driven_R2: assert property (@(posedge clk) disable iff (!srst_n)
    !ext_wr_n |-> ext_doe);

  assert_full_blocks_R4: assert property (@(posedge clk) disable iff (!srst_n)
    $fell(ext_wr_n) |-> !($past(full_gate_en) && $past(ext_full)));

  assert_empty_blocks_R5: assert property (@(posedge clk) disable iff (!srst_n)
    $fell(ext_rd_n) |-> !($past(empty_gate_en) && $past(ext_empty)));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!srst_n)
    done |=> !done);

  assert_abort_flags_R7: assert property (@(posedge clk) disable iff (!srst_n)
    done_err |-> (done && err_flag));

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!srst_n)
    (err_flag && !err_clr) |=> err_flag);

  assert_busy_not_ready_R12: assert property (@(posedge clk) disable iff (!srst_n)
    (!ext_rd_n || !ext_wr_n) |-> !req_ready);
endmodule

bind extfifo_bridge efb_checker u_chk (
  .clk           (clk),
  .srst_n        (srst_n),
  .req_ready     (req_ready),
  .full_gate_en  (full_gate_en),
  .empty_gate_en (empty_gate_en),
  .ext_full      (ext_full),
  .ext_empty     (ext_empty),
  .ext_doe       (ext_doe),
  .ext_rd_n      (ext_rd_n),
  .ext_wr_n      (ext_wr_n),
  .done          (done),
  .done_err      (done_err),
  .err_clr       (err_clr),
  .err_flag      (err_flag)
);

// File: tb/sim_extfifo_bridge.sv
`timescale 1ns/1ps
module sim_extfifo_bridge;
  logic       clk;
  logic       rst_n;
  logic       req_valid, req_write;
  logic [7:0] req_wdata;
  logic       req_ready;
  logic       full_gate_en, empty_gate_en;
  logic       cfg_limit_we;
  logic [7:0] cfg_limit_val;
  logic       err_clr;
  logic       ext_full, ext_empty;
  logic [7:0] ext_din, ext_dout;
  logic       ext_doe, ext_rd_n, ext_wr_n;
  logic       done, done_err;
  logic [7:0] rdata;
  logic       err_flag;

  int nchk = 0;
  int nfail = 0;

  extfifo_bridge u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_wdata(req_wdata), .req_ready(req_ready), .full_gate_en(full_gate_en),
    .empty_gate_en(empty_gate_en), .cfg_limit_we(cfg_limit_we),
    .cfg_limit_val(cfg_limit_val), .err_clr(err_clr), .ext_full(ext_full),
    .ext_empty(ext_empty), .ext_din(ext_din), .ext_dout(ext_dout),
    .ext_doe(ext_doe), .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n), .done(done),
    .done_err(done_err), .rdata(rdata), .err_flag(err_flag)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  initial begin
    #(5.0 * 200000);
    nfail++;
    $display("FAIL watchdog: actual=timeout expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req_valid = 0; req_write = 0; req_wdata = 0;
    full_gate_en = 0; empty_gate_en = 0; cfg_limit_we = 0; cfg_limit_val = 0;
    err_clr = 0; ext_full = 0; ext_empty = 0; ext_din = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic load_limit(input int lim);
    @(negedge clk); cfg_limit_we = 1; cfg_limit_val = 8'(lim);
    @(negedge clk); cfg_limit_we = 0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); err_clr = 1;
    @(negedge clk); err_clr = 0;
  endtask

  // rel: sample index at which both flags drop (-1 = never).
  // raise: raise both flags at the first strobe sample.
  task automatic run_txn(input logic wr, input logic [7:0] wd, input logic [7:0] din,
                         input int rel, input int maxn, input bit raise,
                         output int first_s, output int n_s, output int done_n,
                         output logic derr, output bit ok);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_wdata = wd; ext_din = ~din;
    @(posedge clk); #1;
    req_valid = 0;
    if (rel == 0) begin ext_full = 0; ext_empty = 0; end
    first_s = -1; n_s = 0; done_n = -1; derr = 0; ok = 1;
    for (int n = 1; n <= maxn && done_n < 0; n++) begin
      @(posedge clk); #1;
      if (wr ? !ext_wr_n : !ext_rd_n) begin
        n_s++;
        if (first_s < 0) first_s = n;
        if (req_ready) ok = 0;
        if (wr && (ext_dout !== wd || ext_doe !== 1'b1)) ok = 0;
        if (n_s == 2) ext_din = din;
        if (raise && n_s == 1) begin ext_full = 1; ext_empty = 1; end
      end
      if (wr ? !ext_rd_n : !ext_wr_n) ok = 0;
      if (done) begin done_n = n; derr = done_err; end
      if (n == rel) begin ext_full = 0; ext_empty = 0; end
    end
  endtask

  initial begin
    int fs, ns, dn;
    logic de;
    bit ok;

    do_reset();
    chk(ext_wr_n === 1'b1 && ext_rd_n === 1'b1, "R1 strobes idle", {ext_wr_n, ext_rd_n}, 3);
    chk(done === 1'b0 && err_flag === 1'b0, "R1 done/err low", {done, err_flag}, 0);
    chk(req_ready === 1'b1, "R1 ready", req_ready, 1);

    // R2 / R3: unstalled transfers over a spread of data values
    for (int i = 0; i < 12; i++) begin
      logic [7:0] v;
      v = 8'((i * 53 + 7) ^ (i << 4));
      run_txn(1'b1, v, 8'h00, -1, 10, 0, fs, ns, dn, de, ok);
      chk(fs == 1 && ns == 2 && dn == 3 && !de, "R2 write timing", fs * 100 + ns * 10 + dn, 123);
      chk(ok, "R2 write data/ready R12", ok, 1);
      run_txn(1'b0, 8'h00, v, -1, 10, 0, fs, ns, dn, de, ok);
      chk(fs == 1 && ns == 2 && dn == 3 && !de, "R3 read timing", fs * 100 + ns * 10 + dn, 123);
      chk(rdata === v, "R3 read capture", rdata, v);
      chk(ok, "R3 strobe exclusive/R12", ok, 1);
    end

    // R4 / R5: stall lengths swept, released by the bench
    full_gate_en = 1; empty_gate_en = 1;
    for (int s = 1; s <= 6; s++) begin
      ext_full = 1;
      run_txn(1'b1, 8'(s), 8'h00, s, 20, 0, fs, ns, dn, de, ok);
      chk(fs == s + 1 && ns == 2 && dn == s + 3 && !de, "R4 full stall", fs * 100 + dn, (s + 1) * 100 + s + 3);
      ext_empty = 1;
      run_txn(1'b0, 8'h00, 8'(s * 17), s, 20, 0, fs, ns, dn, de, ok);
      chk(fs == s + 1 && ns == 2 && dn == s + 3 && !de, "R5 empty stall", fs * 100 + dn, (s + 1) * 100 + s + 3);
      chk(rdata === 8'(s * 17), "R5 read data", rdata, s * 17);
    end

    // R6: disabled flags and cross flags have no effect
    for (int c = 0; c < 4; c++) begin
      full_gate_en  = (c == 0 || c == 2) ? 1'b0 : 1'b1;
      empty_gate_en = (c == 1 || c == 2) ? 1'b0 : 1'b1;
      ext_full  = (c != 1);
      ext_empty = (c != 0);
      if (c == 3) begin ext_full = 1; ext_empty = 0; end
      run_txn(c[0] ? 1'b0 : 1'b1, 8'hC3, 8'h3C, -1, 10, 0, fs, ns, dn, de, ok);
      chk(fs == 1 && dn == 3 && !de, "R6 flag ignored", fs * 100 + dn, 103);
      ext_full = 0; ext_empty = 0;
    end

    // R11: flags rising during the strobe
    full_gate_en = 1; empty_gate_en = 1;
    run_txn(1'b1, 8'h11, 8'h00, -1, 10, 1, fs, ns, dn, de, ok);
    chk(ns == 2 && dn == 3, "R11 write strobe fixed", ns * 10 + dn, 23);
    ext_full = 0; ext_empty = 0;
    run_txn(1'b0, 8'h00, 8'h99, -1, 10, 1, fs, ns, dn, de, ok);
    chk(ns == 2 && dn == 3 && rdata === 8'h99, "R11 read strobe fixed", ns * 10 + dn, 23);
    ext_full = 0; ext_empty = 0;

    // R7 / R9 / R10: timeout sweep over loaded limits
    for (int lim = 1; lim <= 8; lim++) begin
      load_limit(lim);
      ext_full = 1;
      run_txn(1'b1, 8'h55, 8'h00, -1, 20, 0, fs, ns, dn, de, ok);
      chk(dn == lim && de && ns == 0, "R7 write abort", dn, lim);
      chk(err_flag === 1'b1, "R7 err set", err_flag, 1);
      ext_full = 0;
      run_txn(1'b1, 8'h66, 8'h00, -1, 10, 0, fs, ns, dn, de, ok);
      chk(err_flag === 1'b1 && dn == 3 && !de, "R10 err sticky", err_flag, 1);
      pulse_clr();
      #1 chk(err_flag === 1'b0, "R10 err cleared", err_flag, 0);
      ext_empty = 1;
      run_txn(1'b0, 8'h00, 8'h00, -1, 20, 0, fs, ns, dn, de, ok);
      chk(dn == lim && de && ns == 0, "R7 read abort", dn, lim);
      ext_empty = 0;
      pulse_clr();
    end

    // R8: limit zero waits forever
    load_limit(0);
    ext_full = 1;
    run_txn(1'b1, 8'h77, 8'h00, 300, 400, 0, fs, ns, dn, de, ok);
    chk(dn == 303 && !de && ns == 2, "R8 no timeout", dn, 303);
    chk(err_flag === 1'b0, "R8 no error", err_flag, 0);

    // R1 / R9: reset value of the limit is 0xFF
    do_reset();
    full_gate_en = 1;
    ext_full = 1;
    run_txn(1'b1, 8'h01, 8'h00, -1, 300, 0, fs, ns, dn, de, ok);
    chk(dn == 255 && de, "R1 limit reset 0xFF", dn, 255);
    ext_full = 0;

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule